// File: doc/BRIEF.md
# Reset-Sampled Strap Configuration Controller

This block turns two dual-purpose three-level mode pins and a three-level line-rate pin into configuration for a line interface. Each pin arrives already decoded as a 2-bit level code. When reset ends, the block takes a one-time snapshot of the mode pins. From that snapshot it sets an attenuator-enable bit and a path-select bit. In the same snapshot it loads a loop-bandwidth select bit whose default follows the line rate.

After the snapshot, the same two mode pins stay live. The transmit pin drives the transmit-driver enable and the monitor pin drives the receive-monitor enable. Neither pin can disturb the latched attenuator bits. A one-cycle register write port can overwrite the three latched bits at any later time. The next reset restores the pin-derived values.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the latched outputs `ja_enable`, `ja_path_rx` and `bw_high` are 0 after that edge.
- R2: On the first rising edge with `rst_n` high after reset, `ja_enable` becomes 1 when either mode pin carries the float code (2'b01), and 0 otherwise.
- R3: On that same edge, `ja_path_rx` becomes 1 only when the monitor pin floats and the transmit pin does not. When both pins float, the transmit path wins and `ja_path_rx` is 0.
- R4: On that same edge, `bw_high` becomes 1 when the line-rate pin carries the high code (2'b10, STS-1). It becomes 0 for the low code (2'b00, E3) and for the float code (2'b01, DS3).
- R5: After the snapshot edge, changes on any of the three pins leave the latched outputs unchanged.
- R6: `tx_drv_en` follows the transmit pin at all times. It is 0 for the low code (2'b00) and 1 for the float and high codes.
- R7: `mon_en` follows the monitor pin at all times. It is 1 only for the high code (2'b10).
- R8: A write (`cfg_wr` high) at an edge after the snapshot loads `cfg_wdata` into the latched bits. Bit 0 goes to `ja_enable`, bit 1 to `ja_path_rx` and bit 2 to `bw_high`. The values are visible after that edge. A write on the snapshot edge itself is ignored.
- R9: The unused level code 2'b11 is treated as the low code on every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_pin_lvl | input | 2 | Decoded transmit mode pin level (00 low, 01 float, 10 high) |
| mon_pin_lvl | input | 2 | Decoded monitor mode pin level |
| rate_pin_lvl | input | 2 | Decoded line-rate pin level (00 E3, 01 DS3, 10 STS-1) |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 3 | Write data {bandwidth, path, enable} |
| ja_enable | output | 1 | Latched attenuator enable |
| ja_path_rx | output | 1 | Latched path select (0 transmit, 1 receive) |
| bw_high | output | 1 | Latched loop-bandwidth select |
| tx_drv_en | output | 1 | Live transmit driver enable |
| mon_en | output | 1 | Live receive monitor enable |

## Verification
The hardest case to reach is the snapshot edge itself. Only one edge per reset counts, so the pins must already hold their intended levels when reset releases. The bench also drives a write strobe on exactly that edge to prove the write is ignored. Each scenario therefore starts with a fresh reset pulse, and the pins are set on the falling edge before release. After release, the pins are moved to levels that would give different snapshot values. The latched outputs must not follow them, while the live enables must.

// File: rtl/strap_cfg_pkg.sv
// Shared types for the strap configuration controller.
// Assumes pins arrive as 2-bit decoded levels; code 2'b11 is unused.
package strap_cfg_pkg;
    localparam int LVL_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_LOW   = 2'b00,
        LVL_FLOAT = 2'b01,
        LVL_HIGH  = 2'b10,
        LVL_RSVD  = 2'b11
    } pin_lvl_e;

    typedef struct packed {
        logic is_low;
        logic is_float;
        logic is_high;
    } lvl_flags_t;

    typedef struct packed {
        logic bw_high;
        logic path_rx;
        logic enable;
    } ja_cfg_t;

    localparam int CFG_W = $bits(ja_cfg_t);
endpackage

// File: rtl/strap_level_decode.sv
// Converts one decoded pin level code into one-hot level flags.
// Assumes the unused code behaves as a low level.
module strap_level_decode
    import strap_cfg_pkg::*;
#(
    parameter int CODE_W = LVL_W
) (
    input  logic [CODE_W-1:0] lvl_code,
    output lvl_flags_t        flags
);
    // Map the raw code onto exactly one level flag.
    always_comb begin
        flags = '0;
        unique case (lvl_code)
            LVL_FLOAT: flags.is_float = 1'b1;
            LVL_HIGH:  flags.is_high  = 1'b1;
            default:   flags.is_low   = 1'b1;
        endcase
    end
endmodule

// File: rtl/strap_cfg_latch.sv
// Holds the attenuator configuration. It snapshots the pin-derived
// values once per reset and then accepts register writes.
// Assumes a synchronous active-low reset and that pins are stable at release.
module strap_cfg_latch
    import strap_cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ja_cfg_t strap_cfg,
    input  logic    wr_en,
    input  ja_cfg_t wr_cfg,
    output ja_cfg_t cfg_q
);
    logic snap_pend;

    // Arm the snapshot during reset; disarm it after the first free edge.
    always_ff @(posedge clk) begin
        if (!rst_n) snap_pend <= 1'b1;
        else        snap_pend <= 1'b0;
    end

    // Clear in reset, take the snapshot once, then accept register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)         cfg_q <= '0;
        else if (snap_pend) cfg_q <= strap_cfg;
        else if (wr_en)     cfg_q <= wr_cfg;
    end
endmodule

// File: rtl/strap_cfg_ctrl.sv
// Top level: decodes the three pins, forms the snapshot configuration,
// drives the live driver and monitor enables and the latched bits.
// Assumes the pin codes are already synchronised to clk.
module strap_cfg_ctrl
    import strap_cfg_pkg::*;
#(
    parameter int NUM_PINS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_pin_lvl,
    input  logic [LVL_W-1:0] mon_pin_lvl,
    input  logic [LVL_W-1:0] rate_pin_lvl,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             ja_enable,
    output logic             ja_path_rx,
    output logic             bw_high,
    output logic             tx_drv_en,
    output logic             mon_en
);
    localparam int PIN_TX   = 0;
    localparam int PIN_MON  = 1;
    localparam int PIN_RATE = 2;

    logic [LVL_W-1:0] pin_code [NUM_PINS];
    lvl_flags_t       pin_flag [NUM_PINS];
    ja_cfg_t          strap_cfg;
    ja_cfg_t          cfg_q;

    // Gather the pin codes into one indexed array.
    always_comb begin
        pin_code[PIN_TX]   = tx_pin_lvl;
        pin_code[PIN_MON]  = mon_pin_lvl;
        pin_code[PIN_RATE] = rate_pin_lvl;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_dec
        strap_level_decode #(.CODE_W(LVL_W)) u_dec (
            .lvl_code (pin_code[g]),
            .flags    (pin_flag[g])
        );
    end

    // Form the pin-derived configuration; a floating transmit pin wins.
    always_comb begin
        strap_cfg.enable  = pin_flag[PIN_TX].is_float | pin_flag[PIN_MON].is_float;
        strap_cfg.path_rx = pin_flag[PIN_MON].is_float & ~pin_flag[PIN_TX].is_float;
        strap_cfg.bw_high = pin_flag[PIN_RATE].is_high;
    end

    strap_cfg_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_cfg (strap_cfg),
        .wr_en     (cfg_wr),
        .wr_cfg    (ja_cfg_t'(cfg_wdata)),
        .cfg_q     (cfg_q)
    );

    // Drive the outputs: latched bits and live enables.
    always_comb begin
        ja_enable  = cfg_q.enable;
        ja_path_rx = cfg_q.path_rx;
        bw_high    = cfg_q.bw_high;
        tx_drv_en  = ~pin_flag[PIN_TX].is_low;
        mon_en     = pin_flag[PIN_MON].is_high;
    end
endmodule

// File: rtl/strap_cfg_checker.sv
// Property checker for strap_cfg_ctrl, attached with bind.
module strap_cfg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] tx_pin_lvl,
    input logic [1:0] mon_pin_lvl,
    input logic [1:0] rate_pin_lvl,
    input logic       cfg_wr,
    input logic [2:0] cfg_wdata,
    input logic       ja_enable,
    input logic       ja_path_rx,
    input logic       bw_high,
    input logic       tx_drv_en,
    input logic       mon_en
);
    logic [1:0] edges_seen = 2'd0;
    logic       prev_rst_n = 1'b1;

    // Count the first edges so history is only used once it exists.
    always_ff @(posedge clk) begin
        if (edges_seen != 2'd3) edges_seen <= edges_seen + 2'd1;
        prev_rst_n <= rst_n;
    end

    // Latched bits are clear one edge after reset was sampled low.
    always_ff @(posedge clk) begin
        if (edges_seen != 2'd0 && !prev_rst_n)
            AST_RESET_CLEAR: assert ({ja_enable, ja_path_rx, bw_high} == 3'b000); // R1
    end

    AST_SNAP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n || edges_seen < 2'd2)
        ($past(rst_n) && !$past(rst_n, 2)) |->
        ja_enable == ($past(tx_pin_lvl) == 2'b01 || $past(mon_pin_lvl) == 2'b01)); // R2

    AST_SNAP_PATH: assert property (@(posedge clk) disable iff (!rst_n || edges_seen < 2'd2)
        ($past(rst_n) && !$past(rst_n, 2) && $past(tx_pin_lvl) == 2'b01) |-> !ja_path_rx); // R3

    AST_SNAP_BW: assert property (@(posedge clk) disable iff (!rst_n || edges_seen < 2'd2)
        ($past(rst_n) && !$past(rst_n, 2)) |-> bw_high == ($past(rate_pin_lvl) == 2'b10)); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n || edges_seen < 2'd2)
        ($past(rst_n) && $past(rst_n, 2) && !$past(cfg_wr)) |->
        $stable({ja_enable, ja_path_rx, bw_high})); // R5

    AST_TX_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pin_lvl == 2'b00 || tx_pin_lvl == 2'b11) |-> !tx_drv_en); // R6

    AST_MON_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mon_en |-> mon_pin_lvl == 2'b10); // R7

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n || edges_seen < 2'd2)
        ($past(cfg_wr) && $past(rst_n) && $past(rst_n, 2)) |->
        {bw_high, ja_path_rx, ja_enable} == $past(cfg_wdata)); // R8
endmodule

bind strap_cfg_ctrl strap_cfg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_pin_lvl   (tx_pin_lvl),
    .mon_pin_lvl  (mon_pin_lvl),
    .rate_pin_lvl (rate_pin_lvl),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .ja_enable    (ja_enable),
    .ja_path_rx   (ja_path_rx),
    .bw_high      (bw_high),
    .tx_drv_en    (tx_drv_en),
    .mon_en       (mon_en)
);

// File: tb/sim_strap_cfg_ctrl.sv
// Scoreboard bench: driver tasks queue expected latched values,
// and a monitor pops and compares them on the falling edge.
module sim_strap_cfg_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tx_pin_lvl = 2'b00, mon_pin_lvl = 2'b00, rate_pin_lvl = 2'b00;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = 3'b000;
    logic       ja_enable, ja_path_rx, bw_high, tx_drv_en, mon_en;

    localparam logic [1:0] LO = 2'b00, FL = 2'b01, HI = 2'b10, RS = 2'b11;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] cfg;  // {bw, path, enable}
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    strap_cfg_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tx_pin_lvl(tx_pin_lvl), .mon_pin_lvl(mon_pin_lvl),
        .rate_pin_lvl(rate_pin_lvl), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ja_enable(ja_enable), .ja_path_rx(ja_path_rx), .bw_high(bw_high),
        .tx_drv_en(tx_drv_en), .mon_en(mon_en)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: compare queued expectations with the latched outputs.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            check(it.tag, {bw_high, ja_path_rx, ja_enable}, it.cfg);
        end
    end

    // Pulse reset with the given pins, then queue the snapshot expectation.
    task automatic do_reset(input logic [1:0] tx, input logic [1:0] mon, input logic [1:0] rate,
                            input logic wr_at_snap, input logic [2:0] exp, input string tag);
        @(negedge clk);
        tx_pin_lvl = tx; mon_pin_lvl = mon; rate_pin_lvl = rate; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset clear", {bw_high, ja_path_rx, ja_enable}, 3'b000);
        rst_n = 1'b1;
        cfg_wr = wr_at_snap; cfg_wdata = 3'b111;
        @(posedge clk);
        exp_q.push_back('{exp, tag});
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(posedge clk);
        exp_q.push_back('{d, "R8 write"});
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Move pins after the snapshot; check live enables and latched hold.
    task automatic move_pins(input logic [1:0] tx, input logic [1:0] mon, input logic [1:0] rate,
                             input logic [2:0] held);
        @(negedge clk);
        tx_pin_lvl = tx; mon_pin_lvl = mon; rate_pin_lvl = rate;
        #1;
        check("R6 tx live", {2'b00, tx_drv_en}, {2'b00, (tx == FL || tx == HI)});
        check("R7 mon live", {2'b00, mon_en}, {2'b00, (mon == HI)});
        @(posedge clk);
        exp_q.push_back('{held, "R5 pins ignored"});
    endtask

    initial begin
        repeat (2) @(posedge clk);
        // Transmit float, E3 -> enable, transmit path, bw 0 (R2 R3 R4)
        do_reset(FL, LO, LO, 1'b0, 3'b001, "R2 tx float snapshot");
        move_pins(LO, FL, HI, 3'b001);
        move_pins(HI, HI, FL, 3'b001);
        move_pins(RS, LO, LO, 3'b001);                    // R9 reserved tx is low
        // Monitor float, STS-1 -> enable, receive path, bw 1
        do_reset(LO, FL, HI, 1'b0, 3'b111, "R3 rx path R4 sts1");
        move_pins(FL, RS, LO, 3'b111);                    // R9 reserved mon is low
        // Both float, DS3 -> transmit priority, bw 0
        do_reset(FL, FL, FL, 1'b0, 3'b001, "R3 both float tx wins");
        do_write(3'b110);
        move_pins(LO, LO, HI, 3'b110);
        do_write(3'b101);
        // Reset restores pin-derived values: all high -> none, bw 0 (R2 R4)
        do_reset(HI, HI, LO, 1'b0, 3'b000, "R2 reset restores");
        // Write on snapshot edge ignored (R8); reserved rate treated low (R9)
        do_reset(LO, LO, RS, 1'b1, 3'b000, "R8 snap write ignored R9 rate");
        do_reset(RS, RS, HI, 1'b0, 3'b100, "R9 reserved mode pins");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule